// File: doc/BRIEF.md
# Pipelined Shift-Add Unsigned Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns the full 2*WIDTH-bit product. The work is spread over WIDTH add stages, one per multiplier bit, with a register bank after each stage. Because every stage holds a different operation, a new operand pair can be presented on every clock and one product leaves the block per clock once the chain has filled.

Each stage uses a narrow (WIDTH+1)-bit adder instead of a full-width one. Stage k looks at one multiplier bit, k. When that bit is set, it adds the multiplicand to the upper part of the running partial product. It then shifts the sum down by one position. The bit that falls out at the bottom can no longer change, so it is appended to a low result field that gains one bit per stage. The forwarded copy of the multiplier loses the bit it has just used, so its register shrinks along the chain. The multiplicand and a valid flag travel with each partial product.

The block is used as a fixed-latency arithmetic unit. The caller drives both operands with the input valid flag. The product must be taken on the cycle the output valid flag is high, because the block has no stall or backpressure path. The reset is synchronous and active-low.

Top module: `pipe_mult`

## Requirements
- R1: When out_valid is high, product equals op_a * op_b as an unsigned 2*WIDTH-bit value, with op_a and op_b taken from the matching accepted input.
- R2: An input that is sampled with in_valid high at a rising edge produces out_valid high after the WIDTH-th rising edge, counting the sampling edge as the first. out_valid stays high for exactly one cycle for that input.
- R3: The block accepts a new operand pair at every rising edge. Back-to-back inputs come out on consecutive cycles, in the order they went in, and each result is independent of its neighbours.
- R4: At a rising edge where rst_n is low, all stage registers are cleared. After that edge out_valid is 0 and product is all zeros.
- R5: An edge where in_valid is low creates a bubble. WIDTH edges later out_valid is low for that slot, while valid inputs on either side still return correct products.
- R6: A multiplier bit of 0 makes its stage add nothing. A multiplier of 0 gives a product of 0, and a multiplier of 1 gives a product equal to the multiplicand.
- R7: All-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1, the largest possible product, with no lost carry.
- R8: A reset applied while operations are in flight discards all of them. No out_valid appears for those inputs after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks op_a/op_b as an operation to start this cycle |
| op_a | input | WIDTH | Unsigned multiplicand |
| op_b | input | WIDTH | Unsigned multiplier |
| out_valid | output | 1 | High for one cycle when product holds a finished result |
| product | output | 2*WIDTH | Unsigned product of the matching inputs |

## Verification
The hardest situation to reach from the ports is a full chain: every stage holds a different live operation, and a reset arrives in the middle of it. Only then can a fault that mixes neighbouring operations, or that leaves stale partial products behind after reset, show up. The stimulus streams operands on every cycle without gaps, so all WIDTH stages are occupied at once. It then inserts bubbles to alternate live and empty slots. Finally it asserts reset while the chain is full and checks that nothing from the discarded operations leaves the block.

// File: rtl/pmul_pkg.sv
// Package pmul_pkg
// Width helpers shared by the multiplier stages, so the narrow register sizes
// are derived in one place. Assumes WIDTH >= 2 and 0 <= idx < WIDTH.
package pmul_pkg;

    // Number of finished low product bits held after stage idx.
    function automatic int lo_width(int idx);
        return idx + 1;
    endfunction

    // Number of multiplier bits still forwarded after stage idx.
    function automatic int mq_keep(int width, int idx);
        return width - idx - 1;
    endfunction

endpackage

// File: rtl/pmul_narrow_add.sv
// Module pmul_narrow_add
// (WIDTH+1)-bit adder for one stage: adds the upper partial product and the
// gated multiplicand. Both are WIDTH bits, so the sum needs one extra bit.
module pmul_narrow_add #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] addend,
    output logic [WIDTH:0]   sum
);

    // Zero-extend both operands and add them, keeping the carry.
    assign sum = {1'b0, acc} + {1'b0, addend};

endmodule

// File: rtl/pmul_stage.sv
// Module pmul_stage
// One add stage of the shift-add chain. It consumes multiplier bit IDX, which
// arrives as bit 0 of in_mq. It adds the gated multiplicand to the upper
// partial product and shifts the sum down one place. The retired low bit goes
// on top of the low result field.
// Assumes: buses are WIDTH bits wide with unused upper bits held at zero, and
// the reset is synchronous and active-low. Registers are only as wide as this
// stage needs: the low field is IDX+1 bits and the forwarded multiplier is
// WIDTH-IDX-1 bits.
module pmul_stage
    import pmul_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_hi,
    input  logic [WIDTH-1:0] in_lo,
    input  logic [WIDTH-1:0] in_mq,
    output logic             out_v,
    output logic [WIDTH-1:0] out_a,
    output logic [WIDTH-1:0] out_hi,
    output logic [WIDTH-1:0] out_lo,
    output logic [WIDTH-1:0] out_mq
);

    localparam int LO_W    = lo_width(IDX);
    localparam int MQ_KEEP = mq_keep(WIDTH, IDX);

    logic [WIDTH-1:0] bit_prod;
    logic [WIDTH:0]   sum;
    logic [WIDTH-1:0] hi_q;
    logic [WIDTH-1:0] a_q;
    logic             v_q;
    logic [LO_W-1:0]  lo_q;
    logic             unused_lo;
    logic             unused_mq;

    // Gate the multiplicand with the multiplier bit this stage consumes.
    assign bit_prod = in_mq[0] ? in_a : '0;

    pmul_narrow_add #(.WIDTH(WIDTH)) u_add (
        .acc    (in_hi),
        .addend (bit_prod),
        .sum    (sum)
    );

    // Register the shifted partial product, the multiplicand and the valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            a_q  <= '0;
            v_q  <= 1'b0;
        end else begin
            hi_q <= sum[WIDTH:1];
            a_q  <= in_a;
            v_q  <= in_v;
        end
    end

    // Low result field: the first stage starts it, later stages extend it.
    generate
        if (IDX == 0) begin : g_lo_first
            always_ff @(posedge clk) begin
                if (!rst_n) lo_q <= '0;
                else        lo_q <= sum[0];
            end
            assign unused_lo = ^in_lo;
        end else begin : g_lo_grow
            always_ff @(posedge clk) begin
                if (!rst_n) lo_q <= '0;
                else        lo_q <= {sum[0], in_lo[IDX-1:0]};
            end
            assign unused_lo = ^in_lo[WIDTH-1:IDX];
        end

        if (LO_W == WIDTH) begin : g_lo_full
            assign out_lo = lo_q;
        end else begin : g_lo_pad
            assign out_lo = {{(WIDTH-LO_W){1'b0}}, lo_q};
        end
    endgenerate

    // Forwarded multiplier: drop the consumed bit and keep only the bits still needed.
    generate
        if (MQ_KEEP > 0) begin : g_mq_fwd
            logic [MQ_KEEP-1:0] mq_q;
            always_ff @(posedge clk) begin
                if (!rst_n) mq_q <= '0;
                else        mq_q <= in_mq[MQ_KEEP:1];
            end
            if (MQ_KEEP + 1 < WIDTH) begin : g_mq_spare
                assign unused_mq = ^in_mq[WIDTH-1:MQ_KEEP+1];
            end else begin : g_mq_none
                assign unused_mq = 1'b0;
            end
            assign out_mq = {{(WIDTH-MQ_KEEP){1'b0}}, mq_q};
        end else begin : g_mq_done
            assign unused_mq = ^in_mq[WIDTH-1:1];
            assign out_mq    = '0;
        end
    endgenerate

    assign out_v  = v_q;
    assign out_a  = a_q;
    assign out_hi = hi_q;

    // A valid bit moves one stage per clock, beside its data.
    assert_valid_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_v == $past(in_v)));

    // A clear multiplier bit only shifts the partial product; nothing is added.
    assert_skip_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_mq[0]))
            |-> ({out_hi, out_lo[IDX]} == {1'b0, $past(in_hi)}));

    // A set multiplier bit adds the multiplicand, and the carry is kept.
    assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_mq[0]))
            |-> ({out_hi, out_lo[IDX]} == ({1'b0, $past(in_hi)} + {1'b0, $past(in_a)})));

endmodule

// File: rtl/pipe_mult.sv
// Module pipe_mult
// Unsigned WIDTH x WIDTH multiplier built as a chain of WIDTH registered
// shift-add stages. It starts one operation per clock and has a fixed latency
// of WIDTH clock edges. Assumes WIDTH >= 2. It has no stall path, so the
// product must be taken when out_valid is high.
module pipe_mult #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] product
);

    localparam int NSTAGE = WIDTH;

    logic [WIDTH-1:0] hi_w [0:NSTAGE];
    logic [WIDTH-1:0] lo_w [0:NSTAGE];
    logic [WIDTH-1:0] mq_w [0:NSTAGE];
    logic [WIDTH-1:0] a_w  [0:NSTAGE];
    logic             v_w  [0:NSTAGE];
    logic             unused_tail;

    // Chain entry: the partial product starts empty and the multiplier is loaded whole.
    assign hi_w[0] = '0;
    assign lo_w[0] = '0;
    assign mq_w[0] = op_b;
    assign a_w[0]  = op_a;
    assign v_w[0]  = in_valid;

    // One stage per multiplier bit.
    generate
        for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
            pmul_stage #(.WIDTH(WIDTH), .IDX(k)) u_stage (
                .clk    (clk),
                .rst_n  (rst_n),
                .in_v   (v_w[k]),
                .in_a   (a_w[k]),
                .in_hi  (hi_w[k]),
                .in_lo  (lo_w[k]),
                .in_mq  (mq_w[k]),
                .out_v  (v_w[k+1]),
                .out_a  (a_w[k+1]),
                .out_hi (hi_w[k+1]),
                .out_lo (lo_w[k+1]),
                .out_mq (mq_w[k+1])
            );
        end
    endgenerate

    // Chain exit: upper half from the last partial product, lower half from the retired bits.
    assign product     = {hi_w[NSTAGE], lo_w[NSTAGE]};
    assign out_valid   = v_w[NSTAGE];
    assign unused_tail = ^{a_w[NSTAGE], mq_w[NSTAGE]};

    // A reset edge leaves no result and a zero product at the outputs.
    assert_reset_clears_R4: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (product == '0)));

endmodule

// File: tb/tb_pipe_mult.sv
// Bench for pipe_mult. A table of operand pairs is streamed through first.
// Directed phases follow for dense random traffic, bubbles, reset while
// operations are in flight, and extreme operands. Every expected output slot
// is scheduled at the cycle its input is driven and compared on the falling edge.
module tb_pipe_mult;

    localparam int W     = 8;
    localparam int DEPTH = 2048;
    localparam int NVEC  = 16;

    // Table entries: op_a in [15:8], op_b in [7:0].
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        16'h0000, 16'h00FF, 16'hFF00, 16'h0101,
        16'h01FF, 16'hFF01, 16'hFFFF, 16'h8080,
        16'h8001, 16'h7F7F, 16'h55AA, 16'hAA55,
        16'h0F10, 16'hF00F, 16'h0203, 16'hC3E7
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [W-1:0]   op_a = '0;
    logic [W-1:0]   op_b = '0;
    logic           out_valid;
    logic [2*W-1:0] product;

    int             cyc = 0;
    int             checks = 0;
    int             failures = 0;
    bit             check_en = 1'b0;
    bit             done = 1'b0;
    bit             sv [DEPTH];
    logic [2*W-1:0] sp [DEPTH];
    string          st [DEPTH];

    always #10 clk = ~clk;

    pipe_mult #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .product   (product)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Compare every output slot against its scheduled expectation.
    always @(negedge clk) begin
        if (check_en && !done && cyc < DEPTH) begin
            checks++;
            if (out_valid !== sv[cyc]) begin
                failures++;
                $display("FAIL %s (R2): cycle %0d out_valid=%0b expected %0b",
                         st[cyc], cyc, out_valid, sv[cyc]);
            end else if (sv[cyc] && product !== sp[cyc]) begin
                failures++;
                $display("FAIL %s (R1): cycle %0d product=%h expected %h",
                         st[cyc], cyc, product, sp[cyc]);
            end
        end
    end

    // Drive one slot and schedule its expected result WIDTH edges later.
    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit v, input string tag);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        in_valid = v;
        if (cyc + W < DEPTH) begin
            sv[cyc+W] = v;
            sp[cyc+W] = {{W{1'b0}}, a} * {{W{1'b0}}, b};
            st[cyc+W] = tag;
        end
    endtask

    // Directed check that the outputs are cleared (R4).
    task automatic check_cleared(input string tag);
        checks++;
        if (out_valid !== 1'b0 || product !== '0) begin
            failures++;
            $display("FAIL %s: out_valid=%0b product=%h expected 0 and %h",
                     tag, out_valid, product, {2*W{1'b0}});
        end
    endtask

    // Reset while operations are in flight; drop their scheduled results (R8).
    task automatic reset_mid_flight();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        for (int i = cyc + 1; i <= cyc + W && i < DEPTH; i++) begin
            sv[i] = 1'b0;
            st[i] = "R8";
        end
        @(negedge clk);
        check_cleared("R4 mid-flight reset");
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            sv[i] = 1'b0;
            sp[i] = '0;
            st[i] = "R5";
        end
        repeat (3) @(negedge clk);
        check_cleared("R4 power-up reset");
        check_en = 1'b1;
        rst_n    = 1'b1;

        // Table of vectors, back to back (R1, R6, R7).
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][15:8], VEC[i][7:0], 1'b1,
                 (VEC[i] == 16'hFFFF) ? "R7" : (VEC[i][7:0] <= 8'h01 ? "R6" : "R1"));
        end

        // Dense random stream so that every stage is occupied (R3).
        for (int i = 0; i < 150; i++) begin
            send(W'($urandom), W'($urandom), 1'b1, "R3");
        end

        // Bubbles between valid inputs (R5).
        for (int i = 0; i < 24; i++) begin
            send(W'($urandom), W'($urandom), (i % 3) != 1, "R5");
        end

        // Fill the chain, then reset it in flight (R8).
        for (int i = 0; i < W; i++) begin
            send(W'($urandom), W'($urandom), 1'b1, "R8");
        end
        reset_mid_flight();
        for (int i = 0; i < W + 2; i++) begin
            send('1, '1, 1'b0, "R8");
        end

        // Extreme operands after recovery (R7, R6).
        send('1, '1, 1'b1, "R7");
        send('1, '0, 1'b1, "R6");
        send('1, W'(1), 1'b1, "R6");
        send('1, '1, 1'b1, "R7");
        send('0, '0, 1'b0, "R5");
        repeat (W + 2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule